// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block gathers two families of event strobes into one pending-interrupt register and reports them on two active-low interrupt lines. One line reports hardware events and the other reports message events. Hardware events are gated by an enable mask. Message events are gated twice: by a global enable bit for their type, and by a per-command enable vector that comes from the descriptor of the last command handled.

A single configuration bit sets the signalling style of both lines. In pulse mode each new interrupt gives a low pulse of fixed width on its line, long enough for an edge-triggered host input. In level mode a line stays low until the host clears it. The host clears one line with that line's own active-high acknowledge input, or clears both lines by reading the pending register. The host reaches the configuration, enable and pending registers through a simple write/read port with a one-cycle read latency.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset both interrupt outputs are high. The configuration register (address 0), the enable register (address 1) and the pending register (address 2) all read as zero, so the block starts in pulse mode.
- R2: A hardware event strobe on `hw_evt[i]` sets pending bit i only if enable bit i is set. When at least one such bit is set, `irq_hw_n` goes low in the cycle after the strobe.
- R3: A message event strobe `msg_evt[k]` sets pending bit 8+k only if enable bit 8+k and `desc_en[k]` are both set. When it does, `irq_msg_n` goes low in the cycle after the strobe.
- R4: Message pending bits sit at fixed positions: bit 8 is count reached zero, bit 9 is a word event, bit 10 is broadcast received, bit 11 is illegal command, and bit 12 is message error. Bits 13 to 15 read as zero.
- R5: With configuration bit 0 clear (pulse mode), each firing drives its output low for exactly PULSE_CYC cycles (13 by default). A new firing during a pulse restarts the full width.
- R6: In pulse mode the acknowledge inputs have no effect on the pulse width.
- R7: With configuration bit 0 set (level mode), a fired output stays low for as long as neither its acknowledge nor a pending read occurs.
- R8: In level mode, a high `ack_hw` clears only `irq_hw_n` and a high `ack_msg` clears only `irq_msg_n`. Neither acknowledge changes the pending register.
- R9: A read of address 2 returns the pending register on `rd_data` one cycle later. The same read clears every pending bit and releases both level-mode outputs.
- R10: An event that arrives in the same cycle as a clear (acknowledge or pending read) wins. Its pending bit stays set and its level-mode output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_evt | input | HW_N | Hardware event strobes, one cycle each |
| msg_evt | input | 5 | Message event strobes, in bit order: count zero, word, broadcast, illegal, error |
| desc_en | input | 5 | Per-command message interrupt enables from the last descriptor |
| ack_hw | input | 1 | Active-high acknowledge for the hardware line (level mode) |
| ack_msg | input | 1 | Active-high acknowledge for the message line (level mode) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 configuration, 1 enable |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address: 0 configuration, 1 enable, 2 pending |
| rd_data | output | DW | Read data, valid the cycle after `rd_en` |
| irq_hw_n | output | 1 | Active-low hardware interrupt |
| irq_msg_n | output | 1 | Active-low message interrupt |

## Verification
Every result in this block is one register deep. An event, an acknowledge or a read presented before a rising edge shows up on `irq_hw_n`, `irq_msg_n`, `rd_data` and the pending state just after that edge. The bench therefore drives inputs on falling edges and samples at the next falling edge. Pulse widths are measured by counting low samples over a window of falling edges, which gives PULSE_CYC low samples for a single firing and the restarted total when a second firing lands mid-pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int MSG_N = 5;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_EN   = 2'd1,
    A_PEND = 2'd2
  } reg_addr_e;

  // message event bit order inside the message field
  typedef enum int {
    M_CNT_ZERO = 0,
    M_WORD     = 1,
    M_BCAST    = 2,
    M_ILLEGAL  = 3,
    M_ERROR    = 4
  } msg_bit_e;

  localparam int N_CHAN = 2;
  localparam int CH_HW  = 0;
  localparam int CH_MSG = 1;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  input  logic [PW-1:0] pend,
  output logic          level_mode,
  output logic [PW-1:0] en_mask,
  output logic          pend_rd,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] rd_mux;

  function automatic logic [DW-1:0] f_widen(input logic [PW-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[PW-1:0] = v;
    return r;
  endfunction

  assign pend_rd = rd_en && (rd_addr == A_PEND);

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      A_CFG:   rd_mux[0] = level_mode;
      A_EN:    rd_mux    = f_widen(en_mask);
      A_PEND:  rd_mux    = f_widen(pend);
      default: rd_mux    = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_mode <= 1'b0;
      en_mask    <= '0;
      rd_data    <= '0;
    end else begin
      if (wr_en && wr_addr == A_CFG) level_mode <= wr_data[0];
      if (wr_en && wr_addr == A_EN)  en_mask    <= wr_data[PW-1:0];
      if (rd_en)                     rd_data    <= rd_mux;
    end
  end

  // R4: unused upper bits of read data never carry a one
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:PW] == '0);
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_pkg::*;
#(
  parameter int HW_N = 8,
  localparam int PW  = HW_N + MSG_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HW_N-1:0]  hw_evt,
  input  logic [MSG_N-1:0] msg_evt,
  input  logic [MSG_N-1:0] desc_en,
  input  logic [PW-1:0]    en_mask,
  input  logic             clr,
  output logic [PW-1:0]    pend,
  output logic             hw_fire,
  output logic             msg_fire
);
  logic [HW_N-1:0]  hw_set;
  logic [MSG_N-1:0] msg_set;
  logic [PW-1:0]    set_vec;

  function automatic logic [HW_N-1:0] f_hw_gate(input logic [HW_N-1:0] ev,
                                                input logic [HW_N-1:0] en);
    return ev & en;
  endfunction

  function automatic logic [MSG_N-1:0] f_msg_gate(input logic [MSG_N-1:0] ev,
                                                  input logic [MSG_N-1:0] glob,
                                                  input logic [MSG_N-1:0] desc);
    return ev & glob & desc;
  endfunction

  function automatic logic [PW-1:0] f_next(input logic [PW-1:0] cur,
                                           input logic [PW-1:0] set,
                                           input logic          clear);
    // a set in the clearing cycle survives
    return (clear ? '0 : cur) | set;
  endfunction

  assign hw_set   = f_hw_gate(hw_evt, en_mask[HW_N-1:0]);
  assign msg_set  = f_msg_gate(msg_evt, en_mask[PW-1:HW_N], desc_en);
  assign set_vec  = {msg_set, hw_set};
  assign hw_fire  = |hw_set;
  assign msg_fire = |msg_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= f_next(pend, set_vec, clr);
  end

  // R2 R3: a newly set pending bit must have been enabled
  p_gated_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend)) & ~$past(en_mask)) == '0);
  p_desc_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend[PW-1:HW_N] & ~$past(pend[PW-1:HW_N])) & ~$past(desc_en)) == '0);
  // R8: without a read, pending bits never drop
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($past(pend) & ~pend) == '0);
  // R9: a read with no new event empties the register
  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hw_fire && !msg_fire |=> pend == '0);
  // R10: an event in the clearing cycle stays pending
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr && (hw_fire || msg_fire) |=> pend != '0);
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int PULSE_CYC = 13,
  localparam int CW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_mode,
  input  logic fire,
  input  logic ack,
  input  logic clr,
  output logic irq_n
);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          release_req;

  assign release_req = ack || clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (level_mode) begin
      cnt_q <= '0;
      if (fire)             lvl_q <= 1'b1;
      else if (release_req) lvl_q <= 1'b0;
    end else begin
      lvl_q <= 1'b0;
      if (fire)              cnt_q <= PULSE_LD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign irq_n = level_mode ? !lvl_q : (cnt_q == '0);

  // R5: the pulse counter never exceeds the programmed width
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PULSE_LD);
  p_pulse_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !level_mode |=> cnt_q == PULSE_LD);
  // R7: a level interrupt holds until released
  p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode && lvl_q && !release_req |=> lvl_q);
  // R8: acknowledge without a new firing releases the line
  p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode && ack && !fire |=> !lvl_q);
  // R10: a firing beats a simultaneous release
  p_fire_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode && fire |=> lvl_q);
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irq_pkg::*;
#(
  parameter int HW_N      = 8,
  parameter int PULSE_CYC = 13,
  parameter int DW        = 16,
  localparam int PW       = HW_N + MSG_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HW_N-1:0]  hw_evt,
  input  logic [MSG_N-1:0] msg_evt,
  input  logic [MSG_N-1:0] desc_en,
  input  logic             ack_hw,
  input  logic             ack_msg,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             irq_hw_n,
  output logic             irq_msg_n
);
  logic          level_mode;
  logic [PW-1:0] en_mask;
  logic [PW-1:0] pend;
  logic          pend_rd;
  logic          hw_fire, msg_fire;
  logic [N_CHAN-1:0] ch_fire, ch_ack, ch_irq_n;

  initial begin
    if (PW > DW) $error("pending field wider than data path");
  end

  irq_regs #(.DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .pend(pend), .level_mode(level_mode), .en_mask(en_mask),
    .pend_rd(pend_rd), .rd_data(rd_data)
  );

  irq_pending #(.HW_N(HW_N)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .hw_evt(hw_evt), .msg_evt(msg_evt), .desc_en(desc_en),
    .en_mask(en_mask), .clr(pend_rd),
    .pend(pend), .hw_fire(hw_fire), .msg_fire(msg_fire)
  );

  assign ch_fire[CH_HW]  = hw_fire;
  assign ch_fire[CH_MSG] = msg_fire;
  assign ch_ack[CH_HW]   = ack_hw;
  assign ch_ack[CH_MSG]  = ack_msg;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    irq_out_stage #(.PULSE_CYC(PULSE_CYC)) u_out (
      .clk(clk), .rst_n(rst_n),
      .level_mode(level_mode), .fire(ch_fire[c]),
      .ack(ch_ack[c]), .clr(pend_rd),
      .irq_n(ch_irq_n[c])
    );
  end

  assign irq_hw_n  = ch_irq_n[CH_HW];
  assign irq_msg_n = ch_irq_n[CH_MSG];

  // R6: in pulse mode an acknowledge alone never lifts an active line
  p_pulse_ack_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !level_mode && $past(!level_mode) && !irq_hw_n && ack_hw && !hw_fire
    && g_chan[CH_HW].u_out.cnt_q > 1 |=> !irq_hw_n);
endmodule

// File: tb/tb_dual_irq_ctrl.sv
module tb_dual_irq_ctrl;
  localparam int HW_N = 8;
  localparam int PCYC = 13;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW_N-1:0] hw_evt = '0;
  logic [4:0] msg_evt = '0, desc_en = '0;
  logic ack_hw = 1'b0, ack_msg = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic irq_hw_n, irq_msg_n;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] rv;
  int lows;

  always #10 clk = ~clk;

  dual_irq_ctrl #(.HW_N(HW_N), .PULSE_CYC(PCYC), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .msg_evt(msg_evt),
    .desc_en(desc_en), .ack_hw(ack_hw), .ack_msg(ack_msg),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_hw_n(irq_hw_n), .irq_msg_n(irq_msg_n)
  );

  typedef struct packed {
    logic        lvl;
    logic [15:0] en;
    logic [7:0]  hw;
    logic [4:0]  msg;
    logic [4:0]  desc;
    logic [15:0] pend;
    logic        hw_n;
    logic        msg_n;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h00FF, 8'h05, 5'b00000, 5'b00000, 16'h0005, 1'b0, 1'b1},
    '{1'b0, 16'h0001, 8'h06, 5'b00000, 5'b00000, 16'h0000, 1'b1, 1'b1},
    '{1'b1, 16'h1F00, 8'h00, 5'b00100, 5'b11111, 16'h0400, 1'b1, 1'b0},
    '{1'b1, 16'h1F00, 8'h00, 5'b11111, 5'b00000, 16'h0000, 1'b1, 1'b1},
    '{1'b1, 16'h0900, 8'h00, 5'b11001, 5'b11111, 16'h0900, 1'b1, 1'b0},
    '{1'b1, 16'h1082, 8'h82, 5'b10000, 5'b10000, 16'h1082, 1'b0, 1'b0},
    '{1'b0, 16'h10FF, 8'h00, 5'b10000, 5'b10000, 16'h1000, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic fire(input logic [7:0] h, input logic [4:0] m);
    hw_evt = h; msg_evt = m;
    @(negedge clk);
    hw_evt = '0; msg_evt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_hw_n && irq_msg_n, "R1 outputs", {irq_hw_n, irq_msg_n}, 3);
    rd(2'd0, rv); chk(rv == 0, "R1 config", rv, 0);
    rd(2'd1, rv); chk(rv == 0, "R1 enable", rv, 0);
    rd(2'd2, rv); chk(rv == 0, "R1 pending", rv, 0);

    // table walk: R2 R3 R4 R9
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, {15'd0, VECS[v].lvl});
      wr(2'd1, VECS[v].en);
      desc_en = VECS[v].desc;
      fire(VECS[v].hw, VECS[v].msg);
      chk(irq_hw_n == VECS[v].hw_n, "R2 hw line", irq_hw_n, VECS[v].hw_n);
      chk(irq_msg_n == VECS[v].msg_n, "R3 msg line", irq_msg_n, VECS[v].msg_n);
      rd(2'd2, rv);
      chk(rv == VECS[v].pend, "R4 pending layout", rv, VECS[v].pend);
      if (VECS[v].lvl)
        chk(irq_hw_n && irq_msg_n, "R9 read releases", {irq_hw_n, irq_msg_n}, 3);
      idle(PCYC + 3);
    end

    // R5 single pulse width
    wr(2'd0, 16'd0);
    wr(2'd1, 16'h1FFF);
    desc_en = 5'b11111;
    fire(8'h01, 5'd0);
    lows = 0;
    for (int i = 0; i < PCYC + 8; i++) begin
      if (!irq_hw_n) lows++;
      @(negedge clk);
    end
    chk(lows == PCYC, "R5 pulse width", lows, PCYC);

    // R5 restart mid-pulse
    fire(8'h01, 5'd0);
    lows = 0;
    for (int i = 0; i < 2 * PCYC + 8; i++) begin
      if (!irq_hw_n) lows++;
      if (i == 4) hw_evt = 8'h01;
      if (i == 5) hw_evt = '0;
      @(negedge clk);
    end
    chk(lows == PCYC + 5, "R5 pulse restart", lows, PCYC + 5);

    // R6 ack ignored in pulse mode
    fire(8'h00, 5'b00001);
    lows = 0;
    for (int i = 0; i < PCYC + 8; i++) begin
      if (!irq_msg_n) lows++;
      ack_msg = (i >= 2 && i < 6);
      ack_hw  = ack_msg;
      @(negedge clk);
    end
    ack_msg = 1'b0; ack_hw = 1'b0;
    chk(lows == PCYC, "R6 pulse ack ignored", lows, PCYC);
    rd(2'd2, rv);

    // R7 R8 level hold and separate acks
    wr(2'd0, 16'd1);
    fire(8'h10, 5'b00010);
    idle(30);
    chk(!irq_hw_n && !irq_msg_n, "R7 level hold", {irq_hw_n, irq_msg_n}, 0);
    ack_hw = 1'b1; @(negedge clk); ack_hw = 1'b0;
    chk(irq_hw_n && !irq_msg_n, "R8 ack_hw only", {irq_hw_n, irq_msg_n}, 2);
    ack_msg = 1'b1; @(negedge clk); ack_msg = 1'b0;
    chk(irq_hw_n && irq_msg_n, "R8 ack_msg", {irq_hw_n, irq_msg_n}, 3);
    rd(2'd2, rv);
    chk(rv == 16'h0210, "R8 pending kept", rv, 16'h0210);
    rd(2'd2, rv);
    chk(rv == 0, "R9 pending emptied", rv, 0);

    // R10 event beats pending read
    fire(8'h01, 5'd0);
    hw_evt = 8'h02; rd_en = 1'b1; rd_addr = 2'd2;
    @(negedge clk);
    hw_evt = '0; rd_en = 1'b0;
    chk(rd_data == 16'h0001, "R10 read data", rd_data, 16'h0001);
    chk(!irq_hw_n, "R10 line after read", irq_hw_n, 0);
    rd(2'd2, rv);
    chk(rv == 16'h0002, "R10 bit survived read", rv, 16'h0002);

    // R10 event beats acknowledge
    fire(8'h04, 5'd0);
    hw_evt = 8'h04; ack_hw = 1'b1;
    @(negedge clk);
    hw_evt = '0; ack_hw = 1'b0;
    chk(!irq_hw_n, "R10 line after ack", irq_hw_n, 0);
    ack_hw = 1'b1; @(negedge clk); ack_hw = 1'b0;
    chk(irq_hw_n, "R8 later ack clears", irq_hw_n, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule